// File: doc/BRIEF.md
# Multi-bank DRAM read timing controller

This block sits between a memory controller's request queue and its command path to a four-bank double data rate DRAM. It takes one request at a time (activate, read, read with auto-precharge, or precharge, with a bank, row and column) and decides in which cycle the request may become a DRAM command. It holds each bank in one of three states: idle, open, or closing. A per-bank down-counter times the activate-to-read delay when the bank is open, and the precharge lockout when it is closing.

A request that is not yet legal is held with `req_ready_o` low until its timing is met and the command path accepts it. An illegal request (a read to a closed bank, an activate to an open bank) is consumed, flagged on `err_o` and never issued. For every issued read the block predicts the read data return and drives `rd_valid_o` for the cycles in which data arrives, two words per clock. Reads to different open banks may be interleaved, so one bank's precharge can be hidden behind another bank's burst.

Top module: `bank_rd_ctrl`

## Requirements
- R1: Opcodes are 0 activate, 1 read, 2 read with auto-precharge, 3 precharge. A read or read with auto-precharge to a bank is issued no earlier than T_RCD cycles after that bank's activate. A read that is already waiting issues in exactly that cycle.
- R2: `rd_valid_o` rises CL cycles after an issued read and stays high for exactly BL/2 cycles, when no other read follows.
- R3: Two reads to different open banks, issued BL/2 cycles apart, give one unbroken `rd_valid_o` window of BL cycles. Neither read is stalled by the other.
- R4: After a read with auto-precharge, the bank closes by itself. Every command to that bank is stalled until BL/2+T_RP cycles after it. An activate is issued in exactly that cycle, and a read in that cycle is refused as a read to a closed bank.
- R5: The lockout of one bank does not stall a read to a different open bank. Such a read is issued in the cycle right after the auto-precharge read.
- R6: A precharge closes its bank. An activate to that bank is issued exactly T_RP cycles after the precharge, no earlier.
- R7: A request that cannot yet issue is held with `req_ready_o` low and `cmd_valid_o` low. With `cmd_ready_i` low nothing issues. At most one command issues per cycle, and only while `cmd_ready_i`, `req_valid_i` and `req_ready_o` are all high.
- R8: A read to a closed bank, or an activate to an open bank, raises `err_o` together with `req_ready_o`, issues no command and leaves the bank state unchanged. A read to that open bank then issues in the next cycle.
- R9: An issued command carries the request's opcode, bank, row and column. `cmd_ap_o` is high only for an issued read with auto-precharge.
- R10: After reset all banks are closed and `rd_valid_o`, `cmd_valid_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | Request opcode (0 act, 1 read, 2 read+auto-precharge, 3 precharge) |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Row address (activate) |
| req_col_i | input | COL_W | Column address (reads) |
| req_ready_o | output | 1 | Request consumed this cycle (issued or refused) |
| cmd_ready_i | input | 1 | Command path can take a command |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_op_o | output | 2 | Issued opcode |
| cmd_bank_o | output | BANK_W | Issued bank |
| cmd_row_o | output | ROW_W | Issued row |
| cmd_col_o | output | COL_W | Issued column |
| cmd_ap_o | output | 1 | Auto-precharge flag of the issued read |
| err_o | output | 1 | Request refused as illegal for the bank state |
| rd_valid_o | output | 1 | Read data is returning this cycle |

## Verification
The checker assumes that the request fields stay unchanged while `req_valid_i` is high and `req_ready_o` is low. It also assumes that `cmd_ready_i` may toggle freely. Its per-bank timing properties count from issued commands only, so they hold whatever the request order. The bench changes inputs only on the falling edge and holds each request until it is consumed. It drives `cmd_ready_i` low only in the stall test. The data-window properties look at the most recent read only, so closely spaced reads that cut an earlier burst short stay within them.

// File: rtl/bank_rd_pkg.sv
package bank_rd_pkg;
  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_RDA = 2'd2,
    OP_PRE = 2'd3
  } dram_op_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_CLOSING = 2'd2
  } bank_st_e;
endpackage

// File: rtl/bank_timer.sv
module bank_timer
  import bank_rd_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int BL    = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     issue_i,
  input  dram_op_e op_i,
  output logic     open_o,
  output logic     busy_o,
  output logic     rd_ok_o
);
  localparam int AP_LEN = BL / 2 + T_RP;
  localparam int CNT_W  = $clog2(AP_LEN + T_RCD + 1);
  localparam logic [CNT_W-1:0] RCD_LD = (T_RCD > 0) ? CNT_W'(T_RCD - 1) : '0;
  localparam logic [CNT_W-1:0] RP_LD  = (T_RP  > 0) ? CNT_W'(T_RP  - 1) : '0;
  localparam logic [CNT_W-1:0] AP_LD  = CNT_W'(AP_LEN - 1);

  bank_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (issue_i && op_i != OP_RD) begin
      unique case (op_i)
        OP_ACT: begin st_q <= BK_OPEN;    cnt_q <= RCD_LD; end
        OP_RDA: begin st_q <= BK_CLOSING; cnt_q <= AP_LD;  end
        default: begin st_q <= BK_CLOSING; cnt_q <= RP_LD; end
      endcase
    end else begin
      unique case (st_q)
        BK_OPEN:    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        BK_CLOSING: if (cnt_q == '0) st_q <= BK_IDLE;
                    else cnt_q <= cnt_q - 1'b1;
        default:    cnt_q <= '0;
      endcase
    end
  end

  // closing with an expired counter behaves as idle
  assign open_o  = (st_q == BK_OPEN);
  assign busy_o  = (st_q == BK_CLOSING) && (cnt_q != '0);
  assign rd_ok_o = open_o && (cnt_q == '0);
endmodule

// File: rtl/issue_ctl.sv
module issue_ctl
  import bank_rd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 req_valid_i,
  input  dram_op_e             op_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 cmd_ready_i,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic [NUM_BANKS-1:0] busy_i,
  input  logic [NUM_BANKS-1:0] rd_ok_i,
  output logic                 issue_o,
  output logic                 err_o,
  output logic                 ready_o
);
  logic is_rd, sel_open, sel_busy, sel_rd_ok, bad, timing_ok;

  always_comb begin
    is_rd     = (op_i == OP_RD) || (op_i == OP_RDA);
    sel_open  = open_i[bank_i];
    sel_busy  = busy_i[bank_i];
    sel_rd_ok = rd_ok_i[bank_i];
    bad       = (is_rd && !sel_open) || (op_i == OP_ACT && sel_open);
    timing_ok = is_rd ? sel_rd_ok : 1'b1;
    err_o     = req_valid_i && !sel_busy && bad;
    issue_o   = req_valid_i && !sel_busy && !bad && timing_ok && cmd_ready_i;
    ready_o   = issue_o || err_o;
  end
endmodule

// File: rtl/rd_window.sv
module rd_window #(
  parameter int CL = 3,
  parameter int BL = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  output logic dv_o
);
  localparam int HALF   = BL / 2;
  localparam int BEAT_W = $clog2(HALF + 1);
  localparam logic [BEAT_W-1:0] BEAT_LD = BEAT_W'(HALF - 1);

  logic [CL-1:0]     dly_q;
  logic [BEAT_W-1:0] beat_q;
  logic              start;

  assign start = dly_q[CL-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q  <= '0;
      beat_q <= '0;
    end else begin
      dly_q <= (dly_q << 1) | CL'(rd_i);
      if (start)              beat_q <= BEAT_LD;
      else if (beat_q != '0)  beat_q <= beat_q - 1'b1;
    end
  end

  // a new burst restarts the count, so bursts BL/2 apart join
  assign dv_o = start || (beat_q != '0);
endmodule

// File: rtl/bank_rd_ctrl.sv
module bank_rd_ctrl
  import bank_rd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int CL        = 3,
  parameter int BL        = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  output logic              req_ready_o,
  input  logic              cmd_ready_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              cmd_ap_o,
  output logic              err_o,
  output logic              rd_valid_o
);
  dram_op_e             op;
  logic [NUM_BANKS-1:0] open_v, busy_v, rd_ok_v;
  logic                 issue;

  assign op = dram_op_e'(req_op_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_timer #(.T_RCD(T_RCD), .T_RP(T_RP), .BL(BL)) timer_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .issue_i (issue && (req_bank_i == BANK_W'(b))),
      .op_i    (op),
      .open_o  (open_v[b]),
      .busy_o  (busy_v[b]),
      .rd_ok_o (rd_ok_v[b])
    );
  end

  issue_ctl #(.NUM_BANKS(NUM_BANKS)) ctl_i (
    .req_valid_i (req_valid_i),
    .op_i        (op),
    .bank_i      (req_bank_i),
    .cmd_ready_i (cmd_ready_i),
    .open_i      (open_v),
    .busy_i      (busy_v),
    .rd_ok_i     (rd_ok_v),
    .issue_o     (issue),
    .err_o       (err_o),
    .ready_o     (req_ready_o)
  );

  rd_window #(.CL(CL), .BL(BL)) win_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (issue && (op == OP_RD || op == OP_RDA)),
    .dv_o   (rd_valid_o)
  );

  assign cmd_valid_o = issue;
  assign cmd_op_o    = issue ? req_op_i   : 2'd0;
  assign cmd_bank_o  = issue ? req_bank_i : '0;
  assign cmd_row_o   = issue ? req_row_i  : '0;
  assign cmd_col_o   = issue ? req_col_i  : '0;
  assign cmd_ap_o    = issue && (op == OP_RDA);
endmodule

// File: rtl/bank_rd_ctrl_chk.sv
module bank_rd_ctrl_chk #(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int CL        = 3,
  parameter int BL        = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              cmd_ready_i,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_op_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic              cmd_ap_o,
  input logic              err_o,
  input logic              rd_valid_o
);
  localparam int WIN_END = CL + BL / 2 - 1;

  logic       cmd_rd;
  logic [7:0] since_rd_q;

  assign cmd_rd = cmd_valid_o && (cmd_op_o == 2'd1 || cmd_op_o == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_rd_q <= 8'hff;
    else if (cmd_rd)            since_rd_q <= 8'd1;
    else if (since_rd_q != 8'hff) since_rd_q <= since_rd_q + 8'd1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
    logic       hit, open_q, pend_q;
    logic [7:0] since_act_q, since_cls_q, cls_len_q;

    assign hit = cmd_valid_o && (cmd_bank_o == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0; pend_q <= 1'b0;
        since_act_q <= 8'hff; since_cls_q <= 8'hff; cls_len_q <= 8'd0;
      end else begin
        if (since_act_q != 8'hff) since_act_q <= since_act_q + 8'd1;
        if (since_cls_q != 8'hff) since_cls_q <= since_cls_q + 8'd1;
        if (hit && cmd_op_o == 2'd0) begin
          open_q <= 1'b1; pend_q <= 1'b0; since_act_q <= 8'd1;
        end else if (hit && (cmd_op_o == 2'd2 || cmd_op_o == 2'd3)) begin
          open_q <= 1'b0; pend_q <= 1'b1; since_cls_q <= 8'd1;
          cls_len_q <= (cmd_op_o == 2'd2) ? 8'(BL / 2 + T_RP) : 8'(T_RP);
        end
      end
    end

    a_r1_rcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && (cmd_op_o == 2'd1 || cmd_op_o == 2'd2) |-> since_act_q >= 8'(T_RCD));
    a_r8_rd_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && (cmd_op_o == 2'd1 || cmd_op_o == 2'd2) |-> open_q);
    a_r8_act_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && cmd_op_o == 2'd0 |-> !open_q);
    a_r4_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && pend_q |-> since_cls_q >= cls_len_q);
  end

  a_r7_one_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_ready_i && req_valid_i && req_ready_o);
  a_r8_err_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !cmd_valid_o && req_ready_o);
  a_r9_ap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ap_o |-> cmd_valid_o && cmd_op_o == 2'd2);
  a_r2_dv_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rd_q >= 8'(CL) && since_rd_q <= 8'(WIN_END) |-> rd_valid_o);
  a_r2_dv_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rd_q > 8'(WIN_END) |-> !rd_valid_o);
endmodule

bind bank_rd_ctrl bank_rd_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD), .T_RP(T_RP), .CL(CL), .BL(BL)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o),
  .cmd_bank_o  (cmd_bank_o),
  .cmd_ap_o    (cmd_ap_o),
  .err_o       (err_o),
  .rd_valid_o  (rd_valid_o)
);

// File: tb/bank_rd_ctrl_tb_top.sv
module bank_rd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, ROW_W = 13, COL_W = 10;
  localparam int T_RCD = 3, T_RP = 3, CL = 3, BL = 8;
  localparam int HALF = BL / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic             req_valid = 1'b0, cmd_ready = 1'b1;
  logic [1:0]       req_op = 2'd0;
  logic [1:0]       req_bank = 2'd0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             req_ready, cmd_valid, cmd_ap, err, rd_valid;
  logic [1:0]       cmd_op, cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  bank_rd_ctrl #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD),
                 .T_RP(T_RP), .CL(CL), .BL(BL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_ready_o(req_ready), .cmd_ready_i(cmd_ready), .cmd_valid_o(cmd_valid),
    .cmd_op_o(cmd_op), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row),
    .cmd_col_o(cmd_col), .cmd_ap_o(cmd_ap), .err_o(err), .rd_valid_o(rd_valid));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic hist [0:4095];
  initial for (int i = 0; i < 4096; i++) hist[i] = 1'b0;
  always @(negedge clk) if (cyc < 4096) hist[cyc] <= rd_valid;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  int cap_err, cap_cv, cap_op, cap_bank, cap_row, cap_col, cap_ap;

  task automatic do_req(input logic [1:0] op, input int bank, input int row,
                        input int col, output int icyc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bank = bank[1:0];
    req_row = row[ROW_W-1:0]; req_col = col[COL_W-1:0];
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    icyc = cyc; cap_err = int'(err); cap_cv = int'(cmd_valid);
    cap_op = int'(cmd_op); cap_bank = int'(cmd_bank); cap_row = int'(cmd_row);
    cap_col = int'(cmd_col); cap_ap = int'(cmd_ap);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) begin @(posedge clk); #1; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int win_ones(input int from, input int len);
    int s = 0;
    for (int i = 0; i < len; i++) s += int'(hist[from + i]);
    return s;
  endfunction

  initial begin
    int a, r, t, t2, u, p, k;
    repeat (3) @(negedge clk);
    chk("R10 cmd_valid in reset", int'(cmd_valid), 0);
    chk("R10 rd_valid in reset", int'(rd_valid), 0);
    chk("R10 err in reset", int'(err), 0);
    rst_n = 1'b1;
    idle(2);
    // all banks closed after reset: read is refused
    do_req(2'd1, 0, 0, 0, r);
    chk("R10 read after reset refused", cap_err, 1);
    chk("R10 no command", cap_cv, 0);

    // R1: activate-to-read delay, every bank
    for (int b = 0; b < NB; b++) begin
      do_req(2'd0, b, 100 + b, 0, a);
      chk("R9 act row", cap_row, 100 + b);
      chk("R9 act bank", cap_bank, b);
      do_req(2'd1, b, 0, 8 * b, r);
      chk("R1 rcd delay", r - a, T_RCD);
      chk("R9 rd col", cap_col, 8 * b);
    end
    idle(CL + HALF + 2);
    chk("R2 last window length", win_ones(r + CL, HALF), HALF);
    chk("R2 last window end", int'(hist[r + CL + HALF]), 0);

    // R2: isolated reads with a gap
    do_req(2'd1, 0, 0, 1, t);
    wait_until(t + HALF + 3);
    do_req(2'd1, 1, 0, 2, t2);
    idle(CL + HALF + 2);
    chk("R2 first window start", int'(hist[t + CL - 1]), 0);
    chk("R2 first window length", win_ones(t + CL, HALF), HALF);
    chk("R2 gap after first window", int'(hist[t + CL + HALF]), 0);
    chk("R2 second window length", win_ones(t2 + CL, HALF), HALF);
    chk("R2 second window end", int'(hist[t2 + CL + HALF]), 0);

    // R3: interleaved reads BL/2 apart give one window
    idle(12);
    do_req(2'd1, 2, 0, 3, t);
    wait_until(t + HALF);
    do_req(2'd1, 3, 0, 4, t2);
    chk("R3 spacing not stalled", t2 - t, HALF);
    idle(CL + BL + 2);
    chk("R3 continuous window", win_ones(t + CL, BL), BL);
    chk("R3 window start", int'(hist[t + CL - 1]), 0);
    chk("R3 window end", int'(hist[t + CL + BL]), 0);

    // R4/R5: auto-precharge lockout per bank, other bank still served
    for (int b = 0; b < NB; b++) begin
      k = (b + 1) % NB;
      do_req(2'd2, b, 0, 5, t);
      chk("R9 ap flag", cap_ap, 1);
      chk("R9 ap opcode", cap_op, 2);
      do_req(2'd1, k, 0, 6, u);
      chk("R5 other bank read", u - t, 1);
      chk("R5 other bank no err", cap_err, 0);
      do_req(2'd0, b, 7, 0, a);
      chk("R4 act after lockout", a - t, HALF + T_RP);
      chk("R4 act issued", cap_cv, 1);
      idle(T_RCD + 1);
    end

    // R4: read stalled by lockout then refused
    do_req(2'd2, 0, 0, 9, t);
    do_req(2'd1, 0, 0, 9, r);
    chk("R4 read held through lockout", r - t, HALF + T_RP);
    chk("R4 read refused after close", cap_err, 1);
    chk("R4 read not issued", cap_cv, 0);
    do_req(2'd0, 0, 1, 0, a);
    chk("R4 reopen", cap_err, 0);
    idle(T_RCD + 1);

    // R6: precharge then activate
    do_req(2'd3, 2, 0, 0, p);
    do_req(2'd0, 2, 3, 0, a);
    chk("R6 act after precharge", a - p, T_RP);
    idle(T_RCD + 1);

    // R8: illegal requests
    do_req(2'd0, 1, 0, 0, t);
    chk("R8 act to open bank flagged", cap_err, 1);
    chk("R8 act to open bank not issued", cap_cv, 0);
    do_req(2'd1, 1, 0, 11, u);
    chk("R8 bank still open, read next cycle", u - t, 1);
    chk("R8 read issued", cap_cv, 1);
    do_req(2'd3, 3, 0, 0, p);
    do_req(2'd1, 3, 0, 0, r);
    chk("R8 read to closed bank flagged", cap_err, 1);
    chk("R6 closed bank held for precharge", r - p, T_RP);
    idle(CL + HALF + 2);

    // R7: command path stall
    @(negedge clk);
    cmd_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd1; req_bank = 2'd1; req_col = 10'd5;
    k = 0;
    for (int i = 0; i < 4; i++) begin
      #1;
      if (req_ready || cmd_valid) k++;
      @(negedge clk);
    end
    chk("R7 held while command path busy", k, 0);
    cmd_ready = 1'b1;
    #1;
    chk("R7 issues when released", int'(cmd_valid), 1);
    chk("R9 stalled read bank", int'(cmd_bank), 1);
    chk("R9 stalled read col", int'(cmd_col), 5);
    chk("R9 plain read no ap", int'(cmd_ap), 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    idle(CL + HALF + 2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule